// File: doc/BRIEF.md
# Ripple-Slice Integer ALU

This block is a purely combinational arithmetic-logic unit. A row of identical one-bit slices is linked by a rippling carry. Each slice picks its output bit from four sources: the AND of its operand bits, the OR of its operand bits, a full-adder sum, or a shared "less" line. The less line is used only by slice zero. Subtraction reuses the adder. An invert control flips every bit of `b`, and the same control supplies the carry into slice zero, so the adder computes `a + ~b + 1`.

A 4-bit operation code selects what the block does: AND, OR, ADD, SUB, signed set-less-than or unsigned set-less-than. The block drives four outputs: the result, the final carry, a two's-complement overflow flag and a zero flag. Overflow is only reported. Acting on it is left to the surrounding pipeline. The width is a parameter and defaults to 32 bits.

Top module: `rip_alu`

## Requirements
- R1: Code 4'b0000 gives `res_o = a_i & b_i`.
- R2: Code 4'b0001 gives `res_o = a_i | b_i`.
- R3: Code 4'b0010 gives `res_o` as the low WIDTH bits of `a_i + b_i`, and `carry_o` as bit WIDTH of that sum.
- R4: Code 4'b0110 gives `res_o` as `a_i - b_i` modulo 2^WIDTH. `carry_o` is the carry out of `a_i + ~b_i + 1`, so it is 1 exactly when `a_i >= b_i` unsigned.
- R5: For code 4'b0010, `ovf_o` is 1 only when both operands have the same sign bit and the sign bit of `res_o` differs from it.
- R6: For code 4'b0110, `ovf_o` is 1 when `a_i` and `b_i` have different sign bits and the sign bit of `res_o` differs from that of `a_i`. Otherwise it is 0.
- R7: Code 4'b0111 gives a `res_o` of all zeros except bit 0. Bit 0 is 1 when `a_i < b_i` as two's-complement numbers. `carry_o` equals the subtraction carry.
- R8: Code 4'b1111 gives a `res_o` of all zeros except bit 0. Bit 0 is 1 when `a_i < b_i` as unsigned numbers. `carry_o` equals the subtraction carry.
- R9: `ovf_o` is 0 for every code other than 4'b0010 and 4'b0110.
- R10: `zero_o` is 1 exactly when every bit of `res_o` is 0.
- R11: `carry_o` is 0 for codes 4'b0000 and 4'b0001.
- R12: Any other code drives `res_o`, `carry_o` and `ovf_o` to 0, so `zero_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 4 | Operation code |
| res_o | output | WIDTH | Result |
| carry_o | output | 1 | Final carry of the slice chain for arithmetic codes |
| ovf_o | output | 1 | Two's-complement overflow for ADD and SUB |
| zero_o | output | 1 | High when the result is all zeros |

## Verification
The checker assumes that every operand and code bit is a known 0 or 1, and that the outputs are read only after the carry chain has settled. It skips evaluation whenever an input carries X.

The bench drives all inputs right after a clock edge and reads the outputs half a period later. This leaves the full ripple time to settle in simulation.

A 4-bit copy of the block is swept over every operand pair and all sixteen codes, undefined codes included. The 32-bit copy sees the sign and range boundaries (0, 1, -1, most positive, most negative) crossed with each other, plus pseudo-random pairs.

// File: rtl/rip_alu_pkg.sv
package rip_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_SUB  = 4'b0110,
    OP_SLT  = 4'b0111,
    OP_SLTU = 4'b1111
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } slice_sel_e;
endpackage

// File: rtl/rip_alu_decode.sv
module rip_alu_decode
  import rip_alu_pkg::*;
(
  input  logic [3:0] op_i,
  output slice_sel_e sel_o,
  output logic       binv_o,
  output logic       valid_o,
  output logic       arith_o,
  output logic       ovf_en_o,
  output logic       unsigned_o
);
  always_comb begin
    sel_o      = SEL_AND;
    binv_o     = 1'b0;
    valid_o    = 1'b1;
    arith_o    = 1'b0;
    ovf_en_o   = 1'b0;
    unsigned_o = 1'b0;
    case (op_i)
      OP_AND: sel_o = SEL_AND;
      OP_OR:  sel_o = SEL_OR;
      OP_ADD, OP_SUB: begin
        sel_o    = SEL_SUM;
        binv_o   = op_i[2];
        arith_o  = 1'b1;
        ovf_en_o = 1'b1;
      end
      OP_SLT, OP_SLTU: begin
        sel_o      = SEL_LESS;
        binv_o     = op_i[2];
        arith_o    = 1'b1;
        unsigned_o = op_i[3];
      end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rip_alu_slice.sv
module rip_alu_slice
  import rip_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       carry_i,
  input  logic       binv_i,
  input  logic       less_i,
  input  slice_sel_e sel_i,
  output logic       res_o,
  output logic       carry_o
);
  logic b_eff, prop, sum;

  assign b_eff   = b_i ^ binv_i;
  assign prop    = a_i ^ b_eff;
  assign sum     = prop ^ carry_i;
  assign carry_o = (a_i & b_eff) | (carry_i & prop);

  always_comb begin
    case (sel_i)
      SEL_AND: res_o = a_i & b_i;
      SEL_OR:  res_o = a_i | b_i;
      SEL_SUM: res_o = sum;
      default: res_o = less_i;
    endcase
  end
endmodule

// File: rtl/rip_alu_chain.sv
module rip_alu_chain
  import rip_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             binv_i,
  input  logic             less_i,
  input  slice_sel_e       sel_i,
  output logic [WIDTH-1:0] res_o,
  output logic             msb_cin_o,
  output logic             carry_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic cin, cout, lin;
    if (i == 0) begin : g_lsb
      assign cin = binv_i;  // +1 turns ~b into -b
      assign lin = less_i;
    end else begin : g_mid
      assign cin = g_bit[i-1].cout;
      assign lin = 1'b0;
    end
    rip_alu_slice u_slice (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .carry_i(cin),
      .binv_i (binv_i),
      .less_i (lin),
      .sel_i  (sel_i),
      .res_o  (res_o[i]),
      .carry_o(cout)
    );
  end

  assign msb_cin_o = g_bit[WIDTH-1].cin;
  assign carry_o   = g_bit[WIDTH-1].cout;
endmodule

// File: rtl/rip_alu_flags.sv
module rip_alu_flags (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic binv_i,
  input  logic msb_cin_i,
  input  logic cout_i,
  input  logic ovf_en_i,
  input  logic unsigned_i,
  output logic less_o,
  output logic ovf_o
);
  logic b_eff, sum_msb, ovf_raw;

  assign b_eff   = b_msb_i ^ binv_i;
  assign sum_msb = a_msb_i ^ b_eff ^ msb_cin_i;
  // sign rule: like-signed addends, result sign flipped
  assign ovf_raw = (a_msb_i ^ sum_msb) & (b_eff ^ sum_msb);
  assign less_o  = unsigned_i ? ~cout_i : (sum_msb ^ ovf_raw);
  assign ovf_o   = ovf_en_i & ovf_raw;
endmodule

// File: rtl/rip_alu.sv
module rip_alu
  import rip_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o
);
  slice_sel_e       sel;
  logic             binv, valid, arith, ovf_en, is_unsigned;
  logic             less, msb_cin, cout, ovf_raw;
  logic [WIDTH-1:0] chain_res;

  rip_alu_decode u_dec (
    .op_i      (op_i),
    .sel_o     (sel),
    .binv_o    (binv),
    .valid_o   (valid),
    .arith_o   (arith),
    .ovf_en_o  (ovf_en),
    .unsigned_o(is_unsigned)
  );

  rip_alu_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i      (a_i),
    .b_i      (b_i),
    .binv_i   (binv),
    .less_i   (less),
    .sel_i    (sel),
    .res_o    (chain_res),
    .msb_cin_o(msb_cin),
    .carry_o  (cout)
  );

  rip_alu_flags u_flags (
    .a_msb_i   (a_i[WIDTH-1]),
    .b_msb_i   (b_i[WIDTH-1]),
    .binv_i    (binv),
    .msb_cin_i (msb_cin),
    .cout_i    (cout),
    .ovf_en_i  (ovf_en),
    .unsigned_i(is_unsigned),
    .less_o    (less),
    .ovf_o     (ovf_raw)
  );

  assign res_o   = valid ? chain_res : '0;
  assign carry_o = arith & cout;
  assign ovf_o   = ovf_raw;
  assign zero_o  = ~|res_o;
endmodule

// File: rtl/rip_alu_chk.sv
module rip_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] res_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             zero_o
);
  logic [WIDTH:0] add_ref, sub_ref;
  logic sa, sb, sr;

  always_comb begin
    add_ref = {1'b0, a_i} + {1'b0, b_i};
    sub_ref = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, 1'b1};
    sa = a_i[WIDTH-1];
    sb = b_i[WIDTH-1];
    sr = res_o[WIDTH-1];
    if (!$isunknown({a_i, b_i, op_i})) begin
      if (op_i == 4'b0010) begin
        a_r3_add_sum: assert ({carry_o, res_o} == add_ref);
        a_r5_add_ovf: assert (ovf_o == ((sa == sb) && (sr != sa)));
      end
      if (op_i == 4'b0110) begin
        a_r4_sub_diff: assert ({carry_o, res_o} == sub_ref);
        a_r6_sub_ovf:  assert (ovf_o == ((sa != sb) && (sr != sa)));
      end
      if (op_i == 4'b0111)
        a_r7_slt: assert (res_o == WIDTH'($signed(a_i) < $signed(b_i)));
      if (op_i == 4'b1111)
        a_r8_sltu: assert (res_o == WIDTH'(a_i < b_i));
      if (op_i != 4'b0010 && op_i != 4'b0110)
        a_r9_no_overflow: assert (!ovf_o);
      a_r10_zero: assert (zero_o == (res_o == '0));
      if (op_i == 4'b0000 || op_i == 4'b0001)
        a_r11_logic_no_carry: assert (!carry_o);
    end
  end
endmodule

bind rip_alu rip_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_rip_alu.sv
`timescale 1ns/1ps
module sim_rip_alu;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int fails  = 0;

  logic [31:0] a0, b0, res0;
  logic [3:0]  op0;
  logic        cy0, ov0, z0;
  logic [3:0]  a1, b1, res1, op1;
  logic        cy1, ov1, z1;

  rip_alu #(.WIDTH(32)) u0 (.a_i(a0), .b_i(b0), .op_i(op0), .res_o(res0),
                            .carry_o(cy0), .ovf_o(ov0), .zero_o(z0));
  rip_alu #(.WIDTH(4))  u1 (.a_i(a1), .b_i(b1), .op_i(op1), .res_o(res1),
                            .carry_o(cy1), .ovf_o(ov1), .zero_o(z1));

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'b0000: return "R1 R9 R10 R11";
      4'b0001: return "R2 R9 R10 R11";
      4'b0010: return "R3 R5 R10";
      4'b0110: return "R4 R6 R10";
      4'b0111: return "R7 R9 R10";
      4'b1111: return "R8 R9 R10";
      default: return "R12 R9 R10";
    endcase
  endfunction

  function automatic longint sval(input int w, input longint unsigned x);
    return x[w-1] ? longint'(x) - longint'(64'd1 << w) : longint'(x);
  endfunction

  task automatic expect_of(input int w, input logic [3:0] op,
                           input longint unsigned a, input longint unsigned b,
                           output longint unsigned r, output logic c,
                           output logic v);
    longint unsigned mask = (64'd1 << w) - 1;
    longint unsigned sum  = a + b;
    longint unsigned dif  = a + ((~b) & mask) + 1;
    logic sa = a[w-1], sb = b[w-1];
    r = 0; c = 0; v = 0;
    case (op)
      4'b0000: r = a & b;
      4'b0001: r = a | b;
      4'b0010: begin
        r = sum & mask; c = sum[w];
        v = (sa == sb) && (r[w-1] != sa);
      end
      4'b0110: begin
        r = dif & mask; c = dif[w];
        v = (sa != sb) && (r[w-1] != sa);
      end
      4'b0111: begin r = (sval(w, a) < sval(w, b)) ? 1 : 0; c = dif[w]; end
      4'b1111: begin r = (a < b) ? 1 : 0; c = dif[w]; end
      default: ;
    endcase
  endtask

  task automatic run(input int w, input logic [3:0] op,
                     input longint unsigned a, input longint unsigned b);
    longint unsigned er, gr;
    logic ec, ev, gc, gv, gz;
    @(posedge clk);
    if (w == 32) begin a0 = a[31:0]; b0 = b[31:0]; op0 = op; end
    else begin a1 = a[3:0]; b1 = b[3:0]; op1 = op; end
    @(negedge clk);
    expect_of(w, op, a, b, er, ec, ev);
    if (w == 32) begin gr = 64'(res0); gc = cy0; gv = ov0; gz = z0; end
    else begin gr = 64'(res1); gc = cy1; gv = ov1; gz = z1; end
    checks++;
    if (gr != er || gc != ec || gv != ev || gz != (er == 0)) begin
      fails++;
      $display("FAIL %s w=%0d op=%b a=%h b=%h: got res=%h c=%b v=%b z=%b exp res=%h c=%b v=%b z=%b",
               tag_of(op), w, op, a, b, gr, gc, gv, gz, er, ec, ev, (er == 0));
    end
  endtask

  logic [3:0] ops [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1111};
  longint unsigned edges [5] = '{64'h0, 64'h1, 64'hFFFF_FFFF, 64'h7FFF_FFFF, 64'h8000_0000};

  initial begin
    a0 = '0; b0 = '0; op0 = '0; a1 = '0; b1 = '0; op1 = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // initial state: zero operands, AND -> zero result (R10)
    run(32, 4'b0000, 0, 0);
    // signed vs unsigned on all-ones and one (R7, R8)
    run(32, 4'b0111, 64'hFFFF_FFFF, 1);
    run(32, 4'b1111, 64'hFFFF_FFFF, 1);
    // exhaustive 4-bit sweep, every code including undefined (R12)
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run(4, 4'(op), longint'(a), longint'(b));
    // 32-bit boundary cross product (R5, R6 at range edges)
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run(32, ops[k], edges[i], edges[j]);
    // 32-bit random operands
    for (int n = 0; n < 400; n++)
      run(32, ops[n % 6], 64'($urandom), 64'($urandom));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule